// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the logic core of a small programmable device. Twelve dedicated inputs and ten feedback lines from bidirectional pins feed the array. Every one of these signals reaches every product term in both true and inverted form. The array then forms, for each of ten outputs, an OR of a fixed group of product terms. The group sizes rise and fall across the outputs, from eight terms at the outer outputs to sixteen in the middle. Each output also has one extra product term of its own, which drives that output's enable and is kept out of the OR.

The connection map is a single flat vector of fuse bits. It is shifted in serially, one bit per clock, while a load strobe is high. Until a complete load has ended, both the sum outputs and the enable outputs are forced to 0. They are forced to 0 again as soon as a new load begins. Output registers, polarity selection and pad drivers sit outside this block and consume `sum_o` and `oe_o`.

Top module: `spla_array`

## Requirements
- R1: After reset, `cfg_done_o`, `sum_o` and `oe_o` are all 0.
- R2: While no complete load has finished, and during any load, `sum_o` and `oe_o` are 0. `cfg_done_o` rises at the first clock edge that samples `cfg_load_i` low after an edge that sampled it high.
- R3: Fuse bits are shifted in at bit 0 first. After a load of TOTAL bits, the first bit sent is fuse bit 0. Term p, column c sits at fuse bit p*44+c. Column 2k is signal k true and column 2k+1 is signal k inverted. Signals 0..11 are `in_i[0..11]` and signals 12..21 are `fb_i[0..9]`. Terms are numbered output by output from output 0 upward. Within one output, the enable term comes first, followed by its sum terms.
- R4: A fuse bit of 1 connects a column to a term. A term with no connected column evaluates to 1.
- R5: A term connected to both the true and the inverted column of the same signal evaluates to 0.
- R6: Output o ORs exactly 8+2*min(o, 9-o) sum terms, so the counts are 8,10,12,14,16,16,14,12,10,8.
- R7: `oe_o[o]` follows only the enable term of output o, which never contributes to `sum_o[o]`.
- R8: The feedback lines `fb_i` act as array inputs exactly like `in_i`.
- R9: Raising `cfg_load_i` again forces all outputs to 0 from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_i | input | 12 | Dedicated logic inputs |
| fb_i | input | 10 | Feedback from bidirectional pins |
| cfg_load_i | input | 1 | Shift strobe for the fuse map |
| cfg_bit_i | input | 1 | Serial fuse bit, fuse bit 0 first |
| sum_o | output | 10 | Sum-of-products result per output |
| oe_o | output | 10 | Enable term result per output |
| cfg_done_o | output | 1 | High once a full load has completed |

## Verification
The bench targets the group boundaries. Every sum term of each output is forced to 0 except the last one, which is wired to one input. If any term count were wrong, the offsets would shift, the free term would land in the wrong group, and some output would no longer follow its input. The bench checks the enable term against a feedback line, so a design that folds the enable into the OR, or that reads `fb_i` in the wrong columns, shows a mismatch on `oe_o`. It also samples the outputs in the middle of a load and right after a reload begins, which exposes a design that lets a half-shifted map drive the outputs.

// File: rtl/spla_pkg.sv
package spla_pkg;

  // Sum-term count of output o: grows by two toward the middle, capped.
  function automatic int terms_of(int o, int n_io, int min_t, int max_t);
    int d;
    int n;
    d = (o < n_io - 1 - o) ? o : (n_io - 1 - o);
    n = min_t + 2 * d;
    return (n > max_t) ? max_t : n;
  endfunction

  // Index of the first term (the enable term) of output o.
  function automatic int term_base(int o, int n_io, int min_t, int max_t);
    int acc;
    acc = 0;
    for (int j = 0; j < o; j++) acc += terms_of(j, n_io, min_t, max_t) + 1;
    return acc;
  endfunction

  function automatic int total_terms(int n_io, int min_t, int max_t);
    return term_base(n_io, n_io, min_t, max_t);
  endfunction

endpackage

// File: rtl/spla_cfg.sv
module spla_cfg #(
  parameter int TOTAL_BITS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic                  bit_i,
  output logic [TOTAL_BITS-1:0] fuse_o,
  output logic                  done_o
);

  logic load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fuse_o <= '0;
      load_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      load_q <= load_i;
      if (load_i) begin
        fuse_o <= {bit_i, fuse_o[TOTAL_BITS-1:1]};
        done_o <= 1'b0;
      end else if (load_q) begin
        done_o <= 1'b1;
      end
    end
  end

  // R9
  load_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !done_o);

  // R2
  done_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q && !load_i) |=> done_o);

endmodule

// File: rtl/spla_pterm.sv
module spla_pterm #(
  parameter int N_COL = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_COL-1:0] cols_i,
  input  logic [N_COL-1:0] fuse_i,
  output logic             term_o
);

  localparam int N_PAIR = N_COL / 2;

  logic [N_PAIR-1:0] pair_clash;

  assign term_o = &(cols_i | ~fuse_i);

  for (genvar k = 0; k < N_PAIR; k++) begin : g_pair
    assign pair_clash[k] = fuse_i[2*k] & fuse_i[2*k+1];
  end

  // R4
  blank_term_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_i == '0) |-> term_o);

  // R5
  clash_term_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pair_clash) |-> !term_o);

endmodule

// File: rtl/spla_group.sv
module spla_group #(
  parameter int N_TERMS = 8,
  parameter int N_COL   = 44
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_COL-1:0]               cols_i,
  input  logic [(N_TERMS+1)*N_COL-1:0]   fuse_i,
  input  logic                           en_i,
  output logic                           sum_o,
  output logic                           oe_o
);

  // term 0 is the enable term, terms 1..N_TERMS feed the OR
  logic [N_TERMS:0] terms;

  for (genvar t = 0; t <= N_TERMS; t++) begin : g_term
    spla_pterm #(.N_COL(N_COL)) i_pterm (
      .clk    (clk),
      .rst_n  (rst_n),
      .cols_i (cols_i),
      .fuse_i (fuse_i[t*N_COL +: N_COL]),
      .term_o (terms[t])
    );
  end

  assign sum_o = en_i & (|terms[N_TERMS:1]);
  assign oe_o  = en_i & terms[0];

endmodule

// File: rtl/spla_array.sv
module spla_array #(
  parameter int N_IN  = 12,
  parameter int N_IO  = 10,
  parameter int MIN_T = 8,
  parameter int MAX_T = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] in_i,
  input  logic [N_IO-1:0] fb_i,
  input  logic            cfg_load_i,
  input  logic            cfg_bit_i,
  output logic [N_IO-1:0] sum_o,
  output logic [N_IO-1:0] oe_o,
  output logic            cfg_done_o
);

  localparam int N_SIG      = N_IN + N_IO;
  localparam int N_COL      = 2 * N_SIG;
  localparam int N_TERM_ALL = spla_pkg::total_terms(N_IO, MIN_T, MAX_T);
  localparam int TOTAL_BITS = N_TERM_ALL * N_COL;

  logic [N_SIG-1:0]      sig;
  logic [N_COL-1:0]      cols;
  logic [TOTAL_BITS-1:0] fuse;

  assign sig = {fb_i, in_i};

  for (genvar k = 0; k < N_SIG; k++) begin : g_col
    assign cols[2*k]   = sig[k];
    assign cols[2*k+1] = ~sig[k];
  end

  spla_cfg #(.TOTAL_BITS(TOTAL_BITS)) i_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (cfg_load_i),
    .bit_i  (cfg_bit_i),
    .fuse_o (fuse),
    .done_o (cfg_done_o)
  );

  for (genvar g = 0; g < N_IO; g++) begin : g_out
    localparam int NT   = spla_pkg::terms_of(g, N_IO, MIN_T, MAX_T);
    localparam int BASE = spla_pkg::term_base(g, N_IO, MIN_T, MAX_T);
    spla_group #(.N_TERMS(NT), .N_COL(N_COL)) i_group (
      .clk    (clk),
      .rst_n  (rst_n),
      .cols_i (cols),
      .fuse_i (fuse[BASE*N_COL +: (NT+1)*N_COL]),
      .en_i   (cfg_done_o),
      .sum_o  (sum_o[g]),
      .oe_o   (oe_o[g])
    );
  end

  // R2
  idle_outputs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done_o |-> (sum_o == '0) && (oe_o == '0));

endmodule

// File: tb/test_spla_array.sv
`timescale 1ns/1ps
module test_spla_array;

  localparam int NCOL = 44;
  localparam int NTRM = 130;
  localparam int TOTB = NTRM * NCOL;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] in_i = '0;
  logic [9:0]  fb_i = '0;
  logic        cfg_load_i = 1'b0;
  logic        cfg_bit_i = 1'b0;
  logic [9:0]  sum_o, oe_o;
  logic        cfg_done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [TOTB-1:0] fz;

  always #2.5 clk = ~clk;

  spla_array i_spla_array (
    .clk(clk), .rst_n(rst_n), .in_i(in_i), .fb_i(fb_i),
    .cfg_load_i(cfg_load_i), .cfg_bit_i(cfg_bit_i),
    .sum_o(sum_o), .oe_o(oe_o), .cfg_done_o(cfg_done_o)
  );

  function automatic int cnt(int o);
    return (o < 5) ? 8 + 2*o : 8 + 2*(9 - o);
  endfunction

  // term number of slot s of output o (slot 0 = enable, 1.. = sum terms)
  function automatic int tnum(int o, int s);
    int p = 0;
    for (int j = 0; j < o; j++) p += cnt(j) + 1;
    return p + s;
  endfunction

  task automatic connect(int o, int s, int sg, bit inv);
    fz[tnum(o, s)*NCOL + 2*sg + (inv ? 1 : 0)] = 1'b1;
  endtask

  task automatic model(input logic [11:0] a, input logic [9:0] f,
                       output logic [9:0] s, output logic [9:0] e);
    logic [21:0] v;
    int p;
    bit tv;
    v = {f, a};
    p = 0;
    s = '0;
    e = '0;
    for (int o = 0; o < 10; o++) begin
      for (int t = 0; t <= cnt(o); t++) begin
        tv = 1;
        for (int c = 0; c < NCOL; c++)
          if (fz[p*NCOL + c] && ((c % 2 == 1) ? v[c/2] : !v[c/2])) tv = 0;
        if (t == 0) e[o] = tv;
        else if (tv) s[o] = 1'b1;
        p++;
      end
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_and_check(string req, logic [11:0] a, logic [9:0] f);
    logic [9:0] es, ee;
    @(negedge clk);
    in_i = a;
    fb_i = f;
    #1;
    model(a, f, es, ee);
    check({req, " sum"}, {22'd0, sum_o}, {22'd0, es});
    check({req, " oe"}, {22'd0, oe_o}, {22'd0, ee});
  endtask

  task automatic load_map(bit mid_chk);
    for (int b = 0; b < TOTB; b++) begin
      @(negedge clk);
      if (mid_chk && b == TOTB/2) begin
        check("R2 mid-load outputs", {12'd0, sum_o, oe_o}, 32'd0);
        check("R2 mid-load done", {31'd0, cfg_done_o}, 32'd0);
      end
      cfg_load_i = 1'b1;
      cfg_bit_i = fz[b];
    end
    @(negedge clk);
    cfg_load_i = 1'b0;
    @(negedge clk);
    check("R2 done after load", {31'd0, cfg_done_o}, 32'd1);
  endtask

  task automatic t_reset();
    check("R1 reset sum", {22'd0, sum_o}, 32'd0);
    check("R1 reset oe", {22'd0, oe_o}, 32'd0);
    check("R1 reset done", {31'd0, cfg_done_o}, 32'd0);
  endtask

  task automatic t_blank();
    fz = '0;
    load_map(1);
    apply_and_check("R4 blank", 12'h000, 10'h000);
    apply_and_check("R4 blank", 12'hA5C, 10'h2F1);
    check("R4 all ones", {12'd0, sum_o, oe_o}, 32'hFFFFF);
  endtask

  task automatic t_conflict();
    fz = '0;
    for (int o = 0; o < 10; o++)
      for (int s = 0; s <= cnt(o); s++) begin
        connect(o, s, (o + s) % 22, 0);
        connect(o, s, (o + s) % 22, 1);
      end
    load_map(0);
    apply_and_check("R5 clash", 12'hFFF, 10'h3FF);
    check("R5 all zero", {12'd0, sum_o, oe_o}, 32'd0);
  endtask

  task automatic t_groups();
    fz = '0;
    for (int o = 0; o < 10; o++) begin
      for (int s = 1; s < cnt(o); s++) begin
        connect(o, s, 3, 0);
        connect(o, s, 3, 1);
      end
      connect(o, cnt(o), o, 0);      // last sum term: in_i[o]
      connect(o, 0, 12 + o, 1);      // enable term: ~fb_i[o]
    end
    load_map(0);
    apply_and_check("R6 R3 groups", 12'h155, 10'h0F0);
    check("R6 sum follows in", {22'd0, sum_o}, 32'h155);
    check("R7 oe follows ~fb", {22'd0, oe_o}, 32'h30F);
    apply_and_check("R6 R7 groups", 12'hAAA, 10'h30C);
    check("R7 oe independent of sum", {22'd0, oe_o}, 32'h0F3);
  endtask

  task automatic t_logic();
    fz = '0;
    for (int o = 0; o < 10; o++) begin
      connect(o, 1, o, 0);
      connect(o, 1, 12 + ((o + 3) % 10), 0);
      connect(o, 2, (o + 5) % 12, 1);
      connect(o, 2, 12 + o, 0);
      for (int s = 3; s <= cnt(o); s++) connect(o, s, 21, 0);
      connect(o, 0, (o + 1) % 12, 0);
    end
    load_map(0);
    apply_and_check("R8 fb terms", 12'h000, 10'h000);
    apply_and_check("R8 fb terms", 12'hFFF, 10'h155);
    apply_and_check("R8 R3 mixed", 12'h3C9, 10'h2AA);
    apply_and_check("R8 R3 mixed", 12'h9E4, 10'h3FF);
  endtask

  task automatic t_reload();
    @(negedge clk);
    cfg_load_i = 1'b1;
    cfg_bit_i = 1'b0;
    @(negedge clk);
    check("R9 reload outputs", {12'd0, sum_o, oe_o}, 32'd0);
    check("R9 reload done", {31'd0, cfg_done_o}, 32'd0);
    cfg_load_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_blank();
    t_conflict();
    t_groups();
    t_logic();
    t_reload();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule